// File: doc/BRIEF.md
# 24-bit address load/store unit

This unit carries out the address-type data moves of a small processor whose registers hold 24 bits while its memory is organised in 32-bit words. Each accepted operation is either a pure register move (from another register, from a short immediate, from the stack pointer or from the program counter, or into the stack pointer) or a single memory access. A memory access can address through a general base register or the stack pointer, with plain, post-increment, post-decrement or pre-decrement addressing. It can also address at an offset from the stack pointer or at an absolute address.

The surrounding pipeline presents a decoded operation code, a mode, the operand register values, the stack pointer, the program counter and an offset that has already been extended. It pulses `start` while `ready` is high. The unit then either produces its write-back one cycle later, or raises one memory request and holds it until the memory acknowledges. After that it presents the destination value and the updated pointer, each with its own one-cycle write strobe.

Top module: `addr_move_unit`

## Requirements
- R1: A memory load (kind 6 through the base, 8 stack-relative, 10 absolute) returns bits 23:0 of the acknowledged 32-bit word as the destination value and discards bits 31:24.
- R2: A store (kind 7 through the base, 9 stack-relative, 11 absolute) drives a write request whose bits 23:0 equal the source value and whose bits 31:24 are zero, and it produces no destination write.
- R3: For base accesses, the mode field selects the addressing (0 plain, 1 post-increment, 2 post-decrement, 3 pre-decrement), and `base_is_sp` = 1 selects the stack pointer as the base. Post-increment accesses at the old base and then writes back base+4. Post-decrement accesses at the old base and then writes back base-4. The write-back is flagged as a stack-pointer update when the stack pointer is the base.
- R4: Pre-decrement (mode 3) accesses at base-4 and writes back base-4.
- R5: Plain base mode addresses base+offset with no pointer write-back. Stack-relative kinds address sp+offset, and absolute kinds use the offset as the address.
- R6: Kind 2 yields the stack pointer with bits 1:0 cleared. Kind 4 writes the stack pointer with bits 23:2 from the source and keeps bits 1:0.
- R7: Kind 5 writes the stack pointer with bits 6:2 from offset bits 6:2, bits 23:7 cleared and bits 1:0 kept.
- R8: Kind 0 copies the source, kind 1 yields offset bits 6:0 zero-extended, and kind 3 yields PC+2. Each is presented one cycle after acceptance.
- R9: A memory operation raises exactly one request. The request holds a stable address and direction until acknowledged. Every write-back strobe is a single cycle, in the cycle after the acknowledge.
- R10: All address and pointer arithmetic wraps modulo 2^24.
- R11: After reset, `ready` is high with no request and no write strobe. A `start` seen while `ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept an operation when ready |
| kind | input | 4 | Operation code |
| mode | input | 2 | Base addressing mode |
| base_is_sp | input | 1 | Use the stack pointer as base |
| rs_val | input | 24 | Source register value |
| rb_val | input | 24 | Base register value |
| sp_val | input | 24 | Stack pointer value |
| pc_val | input | 24 | Program counter value |
| ofs | input | 24 | Extended offset / immediate |
| ready | output | 1 | Idle, able to accept |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 32 | Write word |
| mem_rdata | input | 32 | Read word |
| mem_ack | input | 1 | Memory acknowledge |
| rd_we | output | 1 | Destination write strobe |
| rd_data | output | 24 | Destination value |
| ptr_we | output | 1 | Pointer write strobe |
| ptr_is_sp | output | 1 | Pointer write targets the stack pointer |
| ptr_data | output | 24 | Updated pointer value |

## Verification
A load with post-increment or post-decrement addressing produces the destination write and the pointer write in the same cycle, right after the acknowledge. The bench issues such loads through both a general base and the stack pointer, with ack delays from zero to three cycles. A per-clock reference model checks both strobes and both values in that single cycle. The bench also pulses `start` during a stalled request and expects the held address and the later idle cycles to show no trace of it.

// File: rtl/addr_move_unit.sv
module addr_move_unit #(
  parameter int AW   = 24,
  parameter int DW   = 32,
  parameter int IMMW = 7,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    kind,
  input  logic [1:0]    mode,
  input  logic          base_is_sp,
  input  logic [AW-1:0] rs_val,
  input  logic [AW-1:0] rb_val,
  input  logic [AW-1:0] sp_val,
  input  logic [AW-1:0] pc_val,
  input  logic [AW-1:0] ofs,
  output logic          ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          rd_we,
  output logic [AW-1:0] rd_data,
  output logic          ptr_we,
  output logic          ptr_is_sp,
  output logic [AW-1:0] ptr_data
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);
  localparam logic [AW-1:0] PC_INC = AW'(2);
  localparam logic [3:0] K_MOVR = 4'd0, K_MOVI = 4'd1, K_RDSP = 4'd2, K_RDPC = 4'd3,
                         K_SPWR = 4'd4, K_SPIM = 4'd5, K_LDB  = 4'd6, K_STB  = 4'd7,
                         K_LDS  = 4'd8, K_STS  = 4'd9, K_LDA  = 4'd10, K_STA = 4'd11;
  localparam logic [1:0] M_PLAIN = 2'd0, M_POSTI = 2'd1, M_POSTD = 2'd2, M_PRED = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_MEM, S_WB} st_t;
  st_t state;

  logic [AW-1:0] base, base_up, base_dn;
  logic          c_mem, c_rdw, c_ptrw, c_ptrsp;
  logic [AW-1:0] c_addr, c_rd, c_ptr;

  logic          st_q, rdw_q, ptrw_q, ptrsp_q;
  logic [AW-1:0] addr_q, rd_q, ptr_q, wd_q;
  wire           rdata_top_unused = ^mem_rdata[DW-1:AW];

  assign base    = base_is_sp ? sp_val : rb_val;
  assign base_up = base + STEP_V;
  assign base_dn = base - STEP_V;
  assign c_mem   = (kind >= K_LDB) && (kind <= K_STA);

  // R3 R4 R5 R6 R7 R8 R10: operation decode
  always_comb begin
    c_addr  = base;
    c_rdw   = 1'b0;
    c_rd    = '0;
    c_ptrw  = 1'b0;
    c_ptrsp = 1'b1;
    c_ptr   = base_up;
    case (kind)
      K_MOVR: begin c_rdw = 1'b1; c_rd = rs_val; end
      K_MOVI: begin c_rdw = 1'b1; c_rd = {{(AW-IMMW){1'b0}}, ofs[IMMW-1:0]}; end
      K_RDSP: begin c_rdw = 1'b1; c_rd = {sp_val[AW-1:2], 2'b00}; end
      K_RDPC: begin c_rdw = 1'b1; c_rd = pc_val + PC_INC; end
      K_SPWR: begin c_ptrw = 1'b1; c_ptr = {rs_val[AW-1:2], sp_val[1:0]}; end
      K_SPIM: begin
        c_ptrw = 1'b1;
        c_ptr  = {{(AW-IMMW){1'b0}}, ofs[IMMW-1:2], sp_val[1:0]};
      end
      K_LDB, K_STB: begin
        c_rdw   = (kind == K_LDB);
        c_ptrsp = base_is_sp;
        c_ptrw  = (mode != M_PLAIN);
        c_ptr   = (mode == M_POSTI) ? base_up : base_dn;
        case (mode)
          M_PLAIN: c_addr = base + ofs;
          M_PRED:  c_addr = base_dn;
          default: c_addr = base;
        endcase
      end
      K_LDS, K_STS: begin c_rdw = (kind == K_LDS); c_addr = sp_val + ofs; end
      K_LDA, K_STA: begin c_rdw = (kind == K_LDA); c_addr = ofs; end
      default: ;
    endcase
  end

  // R9 R11: sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      st_q    <= 1'b0;
      rdw_q   <= 1'b0;
      ptrw_q  <= 1'b0;
      ptrsp_q <= 1'b0;
      addr_q  <= '0;
      rd_q    <= '0;
      ptr_q   <= '0;
      wd_q    <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          st_q    <= c_mem & kind[0];
          rdw_q   <= c_rdw;
          ptrw_q  <= c_ptrw;
          ptrsp_q <= c_ptrsp;
          addr_q  <= c_addr;
          rd_q    <= c_rd;
          ptr_q   <= c_ptr;
          wd_q    <= rs_val;
          state   <= c_mem ? S_MEM : S_WB;
        end
        S_MEM: if (mem_ack) begin
          if (!st_q) rd_q <= mem_rdata[AW-1:0];
          state <= S_WB;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ready     = (state == S_IDLE);
  assign mem_req   = (state == S_MEM);
  assign mem_we    = mem_req & st_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = {{(DW-AW){1'b0}}, wd_q};
  assign rd_we     = (state == S_WB) & rdw_q;
  assign rd_data   = rd_q;
  assign ptr_we    = (state == S_WB) & ptrw_q;
  assign ptr_is_sp = ptrsp_q;
  assign ptr_data  = ptr_q;
endmodule

module addr_move_unit_chk #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_rdata,
  input logic          mem_ack,
  input logic          rd_we,
  input logic [AW-1:0] rd_data
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  assert_no_early_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> !rd_we);
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |=> !rd_we && ready);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mem_req && !rd_we);
  assert_load_low_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_we |=> rd_we && rd_data == $past(mem_rdata[AW-1:0]));
  assert_store_no_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_we |=> !rd_we && !mem_req);
endmodule

bind addr_move_unit addr_move_unit_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
  .rd_we(rd_we), .rd_data(rd_data)
);

// File: tb/addr_move_unit_test.sv
module addr_move_unit_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, base_is_sp = 1'b0, mem_ack = 1'b0;
  logic [3:0]  kind = '0;
  logic [1:0]  mode = '0;
  logic [23:0] rs_val = '0, rb_val = '0, sp_val = '0, pc_val = '0, ofs = '0;
  logic [31:0] mem_rdata = '0;
  logic        ready, mem_req, mem_we, rd_we, ptr_we, ptr_is_sp;
  logic [23:0] mem_addr, rd_data, ptr_data;
  logic [31:0] mem_wdata;
  int nchk = 0, nerr = 0, cyc = 0;
  logic [31:0] bmem [int];

  always #5 clk = ~clk;

  addr_move_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .mode(mode),
    .base_is_sp(base_is_sp), .rs_val(rs_val), .rb_val(rb_val), .sp_val(sp_val),
    .pc_val(pc_val), .ofs(ofs), .ready(ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .rd_we(rd_we), .rd_data(rd_data), .ptr_we(ptr_we),
    .ptr_is_sp(ptr_is_sp), .ptr_data(ptr_data)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nerr++;
      $display("FAIL watchdog: got cycle %0d expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] wrap(int v);
    return 24'(v % (1 << 24) + ((v < 0) ? (1 << 24) : 0));
  endfunction

  task automatic run_op(string tag, int k, int md, bit usp, int rs, int rb, int sp,
                        int pc, int of, int delay, bit poke);
    bit ismem, isst, e_rdw, e_ptrw, e_sp;
    int base, ea;
    logic [23:0] e_rd, e_ptr;
    logic [31:0] word;
    ismem = (k >= 6 && k <= 11);
    isst  = ismem && (k % 2 == 1);
    base  = usp ? sp : rb;
    e_rdw = 0; e_ptrw = 0; e_sp = 1; e_rd = 0; e_ptr = 0; ea = 0;
    if (k == 0) begin e_rdw = 1; e_rd = 24'(rs); end
    if (k == 1) begin e_rdw = 1; e_rd = 24'(of % 128); end
    if (k == 2) begin e_rdw = 1; e_rd = 24'((sp / 4) * 4); end
    if (k == 3) begin e_rdw = 1; e_rd = wrap(pc + 2); end
    if (k == 4) begin e_ptrw = 1; e_ptr = 24'((rs / 4) * 4 + sp % 4); end
    if (k == 5) begin e_ptrw = 1; e_ptr = 24'(((of % 128) / 4) * 4 + sp % 4); end
    if (k == 6 || k == 7) begin
      e_sp = usp;
      if (md == 0) ea = base + of;
      else if (md == 3) ea = base - 4;
      else ea = base;
      if (md != 0) begin e_ptrw = 1; e_ptr = wrap(md == 1 ? base + 4 : base - 4); end
    end
    if (k == 8 || k == 9) ea = sp + of;
    if (k == 10 || k == 11) ea = of;
    if (ismem && !isst) e_rdw = 1;
    @(negedge clk);
    start = 1; kind = 4'(k); mode = 2'(md); base_is_sp = usp;
    rs_val = 24'(rs); rb_val = 24'(rb); sp_val = 24'(sp); pc_val = 24'(pc); ofs = 24'(of);
    @(negedge clk);
    start = 0;
    if (ismem) begin
      for (int i = 0; i <= delay; i++) begin
        start = 0;
        chk(tag, "mem_req", {31'b0, mem_req}, 32'd1);
        chk(tag, "mem_addr", {8'b0, mem_addr}, {8'b0, wrap(ea)});
        chk(tag, "mem_we", {31'b0, mem_we}, {31'b0, isst});
        if (isst) chk(tag, "mem_wdata", mem_wdata, {8'h00, 24'(rs)});
        chk(tag, "no wb while waiting", {30'b0, rd_we, ptr_we}, 32'd0);
        chk(tag, "ready low", {31'b0, ready}, 32'd0);
        if (poke && i == 0 && delay > 0) begin start = 1; kind = 4'd0; rs_val = 24'h0BAD00; end
        if (i == delay) begin
          mem_ack = 1;
          word = bmem.exists(int'(wrap(ea))) ? bmem[int'(wrap(ea))]
                                             : {8'hC3, wrap(ea) ^ 24'h5A5A5A};
          mem_rdata = isst ? 32'hFFFFFFFF : word;
          if (isst) bmem[int'(wrap(ea))] = {8'h00, 24'(rs)};
          else e_rd = word[23:0];
        end
        @(negedge clk);
        mem_ack = 0;
      end
      start = 0;
    end
    chk(tag, "rd_we", {31'b0, rd_we}, {31'b0, e_rdw});
    if (e_rdw) chk(tag, "rd_data", {8'b0, rd_data}, {8'b0, e_rd});
    chk(tag, "ptr_we", {31'b0, ptr_we}, {31'b0, e_ptrw});
    if (e_ptrw) begin
      chk(tag, "ptr_data", {8'b0, ptr_data}, {8'b0, e_ptr});
      chk(tag, "ptr_is_sp", {31'b0, ptr_is_sp}, {31'b0, e_sp});
    end
    chk(tag, "mem_req after", {31'b0, mem_req}, 32'd0);
    @(negedge clk);
    chk(tag, "idle after", {29'b0, ready, rd_we, ptr_we}, 32'd4);
    chk(tag, "no request after", {31'b0, mem_req}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "reset ready", {31'b0, ready}, 32'd1);
    chk("R11", "reset strobes", {29'b0, mem_req, rd_we, ptr_we}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R11", "idle after reset", {29'b0, mem_req, rd_we, ptr_we}, 32'd0);
    run_op("R8",  0, 0, 0, 'hABCDEF, 0, 0, 0, 0, 0, 0);
    run_op("R8",  1, 0, 0, 0, 0, 0, 0, 'h1FF, 0, 0);
    run_op("R10", 3, 0, 0, 0, 0, 0, 'hFFFFFF, 0, 0, 0);
    run_op("R8",  3, 0, 0, 0, 0, 0, 'h001230, 0, 0, 0);
    run_op("R6",  2, 0, 0, 0, 0, 'h123457, 0, 0, 0, 0);
    run_op("R6",  4, 0, 0, 'hFFFFFF, 0, 'h000002, 0, 0, 0, 0);
    run_op("R7",  5, 0, 0, 0, 0, 'hABCDE1, 0, 'h7F, 0, 0);
    run_op("R7",  5, 0, 0, 0, 0, 'h000003, 0, 'h48, 0, 0);
    run_op("R1",  6, 0, 0, 0, 'h000100, 0, 0, 0, 0, 0);
    run_op("R2",  7, 0, 0, 'hFEDCBA, 'h000200, 0, 0, 0, 2, 0);
    run_op("R1",  6, 0, 0, 0, 'h000200, 0, 0, 0, 1, 0);
    run_op("R5",  6, 0, 0, 0, 'h000300, 0, 0, 'h10, 0, 0);
    run_op("R3",  6, 1, 0, 0, 'h000300, 'h777770, 0, 0, 1, 0);
    run_op("R3",  7, 2, 1, 'h13579B, 'h000999, 'h000400, 0, 0, 1, 0);
    run_op("R3",  6, 1, 1, 0, 0, 'hFFFFFC, 0, 0, 0, 0);
    run_op("R4",  6, 3, 0, 0, 'h000002, 0, 0, 0, 0, 0);
    run_op("R4",  7, 3, 1, 'h2468AC, 0, 'h000800, 0, 0, 2, 0);
    run_op("R10", 8, 0, 0, 0, 0, 'hFFFFF0, 0, 'h20, 0, 0);
    run_op("R5",  9, 0, 0, 'h00ABCD, 0, 'h000500, 0, 'h40, 1, 0);
    run_op("R5",  11, 0, 0, 'h112233, 0, 0, 0, 'h000555, 0, 0);
    run_op("R5",  10, 0, 0, 0, 0, 0, 0, 'h000555, 0, 0);
    run_op("R9",  6, 2, 0, 0, 'h000040, 0, 0, 0, 3, 1);
    run_op("R11", 7, 1, 0, 'h00FACE, 'h000060, 0, 0, 0, 2, 1);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule